// File: doc/BRIEF.md
# ISA-Style Bus Cycle Sequencer

This block is the only master on an 8-bit expansion bus that has separate address and data lines. A local agent hands it one request at a time. Each request carries an address-space select (memory or I/O), a direction, a 20-bit address and a write byte. The sequencer then runs one bus cycle of fixed length. The cycle opens with an address-latch pulse on the latched address. It then asserts exactly one of four active-low command strobes: memory read, memory write, I/O read or I/O write. It finishes by returning a done pulse and, for reads, the byte it sampled.

The target never acknowledges a cycle, so all timing is counted from the bus clock. A memory cycle takes four clocks and an I/O cycle takes five. An optional ready input lets a slow target stretch the command phase by one clock for each clock it holds ready low. The data bus appears as separate in, out and output-enable ports, so the pad ring can build the tri-state driver.

Top module: `isa_cycle_seq`

## Requirements
- R1: After reset, all four command strobes are high and the following outputs are low: the latch pulse, busy, done and the data output enable.
- R2: A request is accepted on a clock edge where req_valid_i is high and busy_o is low. Cycle clock 1 follows that edge. In clock 1 bus_ale_o is high; in every later clock it is low. bus_addr_o holds the accepted address for the whole cycle. busy_o stays high from clock 1 through the done cycle.
- R3: A memory cycle (req_io_i=0) lasts four clocks. bus_memr_no is low in clocks 2 to 4 for a read (req_wr_i=0), and bus_memw_no is low in those clocks for a write (req_wr_i=1).
- R4: An I/O cycle (req_io_i=1) lasts five clocks. bus_ior_no is low in clocks 2 to 5 for a read, and bus_iow_no is low in those clocks for a write.
- R5: At most one command strobe is low at any time, and no strobe is low while bus_ale_o is high.
- R6: During a write, bus_data_oe_o is high and bus_data_o carries the write byte from clock 2 through the final clock. bus_data_oe_o is low at all other times.
- R7: A read samples bus_data_i on the clock edge that closes the final strobe clock. In the next cycle that byte is presented on rdata_o while done_o is high. A write leaves rdata_o unchanged.
- R8: done_o is high for exactly one cycle, the cycle right after the final clock. In the cycle after that, busy_o is low.
- R9: Each clock in the strobe phase (clock 2 onward) during which bus_ready_i is low repeats that clock, and the strobe stays asserted. bus_ready_i low during clock 1 has no effect.
- R10: A request presented while busy_o is high is ignored, including during the done cycle. The cycle in progress keeps its address, strobe and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Request address |
| req_wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| bus_addr_o | output | 20 | Latched bus address |
| bus_ale_o | output | 1 | Address-latch pulse |
| bus_memr_no | output | 1 | Memory read strobe, active low |
| bus_memw_no | output | 1 | Memory write strobe, active low |
| bus_ior_no | output | 1 | I/O read strobe, active low |
| bus_iow_no | output | 1 | I/O write strobe, active low |
| bus_data_o | output | 8 | Data driven onto the bus |
| bus_data_oe_o | output | 1 | Data output enable |
| bus_data_i | input | 8 | Data sampled from the bus |
| bus_ready_i | input | 1 | Target ready; low stretches the strobe phase |

## Verification
The bench presents a wrong byte on the data bus in every strobe clock except the final one. A design that samples one clock early therefore returns the wrong value. A design that picks the wrong cycle length for the address space leaves a strobe too long or too short, and the clock-by-clock strobe comparison catches it. Ready is pulled low in a middle strobe clock and, in a separate test, only in clock 1. A design that ignores the wait, or that also stalls on the latch clock, ends on a different clock. A request held valid through the whole cycle tests whether a design that accepts it early corrupts the address or restarts the cycle.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_e;
endpackage

// File: rtl/isa_req_reg.sv
module isa_req_reg #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              io_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              io_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_o    <= 1'b0;
      wr_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      io_o    <= io_i;
      wr_o    <= wr_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/isa_cycle_ctr.sv
module isa_cycle_ctr
  import isa_seq_pkg::*;
#(
  parameter int IO_CLKS   = 5,
  parameter int MEM_CLKS  = 4,
  parameter bit USE_READY = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic is_io_i,
  input  logic ready_i,
  output logic busy_o,
  output logic first_o,
  output logic strobe_o,
  output logic capture_o,
  output logic done_o
);
  localparam int MAX_CLKS = (IO_CLKS > MEM_CLKS) ? IO_CLKS : MEM_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic             rdy;

  generate
    if (USE_READY) begin : g_ready
      assign rdy = ready_i;
    end else begin : g_noready
      assign rdy = 1'b1;
    end
  endgenerate

  assign len = is_io_i ? CNT_W'(IO_CLKS) : CNT_W'(MEM_CLKS);

  wire in_strobe = (state_q == ST_RUN) && (cnt_q >= CNT_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= CNT_W'(1);
        end
        ST_RUN: begin
          if (in_strobe && !rdy) begin
            cnt_q <= cnt_q;            // wait state
          end else if (cnt_q == len) begin
            state_q <= ST_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign first_o   = (state_q == ST_RUN) && (cnt_q == CNT_W'(1));
  assign strobe_o  = in_strobe;
  assign capture_o = in_strobe && rdy && (cnt_q == len);
  assign done_o    = (state_q == ST_DONE);

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q >= CNT_W'(1) && cnt_q <= len));
  // R8
  done_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/isa_strobe_drv.sv
module isa_strobe_drv (
  input  logic io_i,
  input  logic wr_i,
  input  logic first_i,
  input  logic strobe_i,
  output logic ale_o,
  output logic memr_no,
  output logic memw_no,
  output logic ior_no,
  output logic iow_no,
  output logic data_oe_o
);
  always_comb begin
    ale_o     = first_i;
    memr_no   = !(strobe_i && !io_i && !wr_i);
    memw_no   = !(strobe_i && !io_i &&  wr_i);
    ior_no    = !(strobe_i &&  io_i && !wr_i);
    iow_no    = !(strobe_i &&  io_i &&  wr_i);
    data_oe_o = strobe_i && wr_i;
  end
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int IO_CLKS   = 5,
  parameter int MEM_CLKS  = 4,
  parameter bit USE_READY = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_io_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_ale_o,
  output logic              bus_memr_no,
  output logic              bus_memw_no,
  output logic              bus_ior_no,
  output logic              bus_iow_no,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_ready_i
);
  logic start, cur_io, cur_wr, first, strobe, capture;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] rdata_q;

  assign start = req_valid_i && !busy_o;

  isa_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .io_i    (req_io_i),
    .wr_i    (req_wr_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .io_o    (cur_io),
    .wr_o    (cur_wr),
    .addr_o  (bus_addr_o),
    .wdata_o (cur_wdata)
  );

  isa_cycle_ctr #(.IO_CLKS(IO_CLKS), .MEM_CLKS(MEM_CLKS), .USE_READY(USE_READY)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .is_io_i   (cur_io),
    .ready_i   (bus_ready_i),
    .busy_o    (busy_o),
    .first_o   (first),
    .strobe_o  (strobe),
    .capture_o (capture),
    .done_o    (done_o)
  );

  isa_strobe_drv u_drv (
    .io_i      (cur_io),
    .wr_i      (cur_wr),
    .first_i   (first),
    .strobe_i  (strobe),
    .ale_o     (bus_ale_o),
    .memr_no   (bus_memr_no),
    .memw_no   (bus_memw_no),
    .ior_no    (bus_ior_no),
    .iow_no    (bus_iow_no),
    .data_oe_o (bus_data_oe_o)
  );

  assign bus_data_o = cur_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (capture && !cur_wr) rdata_q <= bus_data_i;
  end
  assign rdata_o = rdata_q;

  // R5
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~{bus_memr_no, bus_memw_no, bus_ior_no, bus_iow_no}) <= 1);
  // R5
  ale_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |-> (bus_memr_no && bus_memw_no && bus_ior_no && bus_iow_no));
  // R6
  oe_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> (!bus_memw_no || !bus_iow_no));
  // R2
  accept_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> (bus_ale_o && busy_o));
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bus_ale_o) |-> $stable(bus_addr_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/isa_cycle_seq_tb.sv
module isa_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_io = 1'b0, req_wr = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done, ale, memr_n, memw_n, ior_n, iow_n, oe;
  logic [7:0]  rdata, dout;
  logic [19:0] baddr;
  logic [7:0]  din = '0;
  logic        ready = 1'b1;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] last_rd = 8'h00;

  always #4 clk = ~clk;

  isa_cycle_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_io_i(req_io), .req_wr_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .bus_addr_o(baddr), .bus_ale_o(ale),
    .bus_memr_no(memr_n), .bus_memw_no(memw_n), .bus_ior_no(ior_n), .bus_iow_no(iow_n),
    .bus_data_o(dout), .bus_data_oe_o(oe), .bus_data_i(din), .bus_ready_i(ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // One full bus cycle; ready is low in cycles [lo_from, lo_from+lo_len)
  task automatic run_cycle(input bit io, input bit wr, input logic [19:0] addr,
                           input logic [7:0] wd, input logic [7:0] rd,
                           input int lo_from, input int lo_len, input bit hold_req,
                           input string tag);
    int len = io ? 5 : 4;
    int cnt = 1;
    bit last;
    logic [3:0] exp_s;
    @(negedge clk);
    chk(!busy, {tag, " idle before"}, busy, 0);
    req_valid = 1; req_io = io; req_wr = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    if (hold_req) begin // R10: conflicting request kept valid while busy
      req_io = !io; req_wr = !wr; req_addr = ~addr; req_wdata = ~wd;
    end else req_valid = 0;
    for (int i = 1; i < 64; i++) begin
      ready = !(i >= lo_from && i < lo_from + lo_len);
      last = (cnt == len) && ready;
      din = last ? rd : ~rd;
      exp_s = 4'b1111;
      if (cnt >= 2) exp_s[{io, wr}] = 1'b0; // index: 0 memr,1 memw,2 ior,3 iow
      chk(ale == (cnt == 1), {tag, " R2 ale"}, ale, cnt == 1);
      chk(busy, {tag, " R2 busy"}, busy, 1);
      chk(baddr == addr, {tag, " R2 addr hold"}, baddr, addr);
      chk({iow_n, ior_n, memw_n, memr_n} == exp_s, {tag, io ? " R4 strobes" : " R3 strobes"},
          {iow_n, ior_n, memw_n, memr_n}, exp_s);
      chk(oe == (wr && cnt >= 2), {tag, " R6 oe"}, oe, wr && cnt >= 2);
      if (wr && cnt >= 2) chk(dout == wd, {tag, " R6 wdata"}, dout, wd);
      chk(!done, {tag, " R8 no early done"}, done, 0);
      if (last) break;
      if (!(cnt >= 2 && !ready)) cnt++; // R9 hold only in strobe phase
      @(negedge clk);
    end
    @(negedge clk);
    ready = 1;
    chk(done, {tag, " R8 done"}, done, 1);
    chk(busy, {tag, " R2 busy in done"}, busy, 1);
    chk({iow_n, ior_n, memw_n, memr_n, oe} == 5'b11110, {tag, " R5 idle strobes"},
        {iow_n, ior_n, memw_n, memr_n, oe}, 5'b11110);
    if (!wr) last_rd = rd;
    chk(rdata == last_rd, {tag, " R7 rdata"}, rdata, last_rd);
    @(negedge clk);
    req_valid = 0;
    chk(!done && !busy, {tag, " R8 idle after done"}, {done, busy}, 0);
  endtask

  task automatic t_reset();
    chk({iow_n, ior_n, memw_n, memr_n} == 4'hF, "R1 strobes", {iow_n, ior_n, memw_n, memr_n}, 4'hF);
    chk({ale, busy, done, oe} == 4'h0, "R1 ctrl", {ale, busy, done, oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_cycle(0, 0, 20'hA5123, 8'h00, 8'h3C, 0, 0, 0, "mem read");
    run_cycle(0, 1, 20'h0F00F, 8'hC3, 8'h99, 0, 0, 0, "mem write");     // R7 rdata unchanged
    run_cycle(1, 0, 20'h003F8, 8'h00, 8'h5A, 0, 0, 0, "io read");
    run_cycle(1, 1, 20'h00378, 8'h81, 8'h11, 0, 0, 0, "io write");
    run_cycle(1, 0, 20'h00060, 8'h00, 8'hE7, 3, 2, 0, "io read wait R9");
    run_cycle(0, 1, 20'hFFFFF, 8'h7E, 8'h00, 1, 1, 0, "mem write ready clk1 R9");
    run_cycle(0, 0, 20'h12345, 8'h00, 8'h96, 4, 1, 0, "mem read wait last R9");
    run_cycle(0, 0, 20'h54321, 8'h00, 8'h0F, 0, 0, 1, "mem read busy req R10");
    run_cycle(1, 1, 20'h00001, 8'h42, 8'h00, 0, 0, 1, "io write busy req R10");
    summary();
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end
endmodule